// File: doc/BRIEF.md
# Shared DRAM Time-Slot Arbiter

This block shares one dynamic RAM between a processor and a video address generator by strict time division. It runs from a fast base clock, nominally 16 MHz. From that clock it derives a processor cycle of `DIV` base clocks, nominally 2 MHz. Each processor cycle is cut into two equal halves, so the RAM sees one access per half, nominally 4 million per second. The first half always belongs to video. The second half belongs to the processor, and the processor clock phase is high during it.

In the video half, the RAM address multiplexer picks the video address and a read takes place. The video side never writes. This read happens every cycle, whether or not the picture needs the byte, so the steady sweep of video addresses also refreshes the DRAM. A one-clock strobe on the last base clock of the video half tells the video pixel logic to capture the byte on the RAM data bus.

In the processor half, the multiplexer picks the processor address. A data-bus transceiver joins the processor bus to the RAM bus only when three things hold: the processor phase is high, the processor's bus enable is high, and the address hits RAM or the video register window. The transceiver direction follows the processor read/write line. At all other times the buses stay split. A slow peripheral access then cannot disturb the video transfer, and the video transfer cannot disturb the processor.

Top module: `dram_slot_arbiter`

## Requirements
- R1: One processor cycle lasts `DIV` base clocks (default 8). Phase counts 0 to `DIV/2-1` form the video half, with `slot_vid`=1 and `cpu_phi2`=0. Counts `DIV/2` to `DIV-1` form the processor half, with `slot_vid`=0 and `cpu_phi2`=1.
- R2: While `rst` is high, the block is in the processor half (`cpu_phi2`=1, `slot_vid`=0), and `xcvr_en`, `xcvr_dir` and `ram_we` are 0. After `rst` falls, phase counting resumes from count `DIV/2`.
- R3: `ram_sel_vid` is 1 exactly in the video half. `ram_addr` equals `vid_addr` in the video half and `cpu_addr` in the processor half.
- R4: `xcvr_en` is 1 when all of these hold: the block is in the processor half, `cpu_en`=1, and `cpu_addr` is below 0x8000 or in the video register window 0xFE20–0xFE2F (base `VREG_BASE`, span `VREG_SPAN`).
- R5: `xcvr_en` is 0 in the video half. It is also 0 for any address outside RAM and the register window (for example 0x8000, 0xC000, 0xFE30), and whenever `cpu_en`=0.
- R6: `xcvr_dir` equals `cpu_rnw` while `xcvr_en`=1, where 1 means data flows toward the processor. It is 0 while `xcvr_en`=0.
- R7: `ram_we` is 1 only in the processor half with `cpu_en`=1, `cpu_rnw`=0 and `cpu_addr` below 0x8000. It is never 1 in the video half, and writes to the register window do not assert it.
- R8: `vid_latch` pulses for exactly one base clock per processor cycle, at phase count `DIV/2-1`. This happens unconditionally, so every cycle yields a video read.
- R9: `slot_start` is 1 on phase counts 0 and `DIV/2` only. It marks the start of each RAM slot, twice per processor cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock (nominal 16 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en | input | 1 | Processor bus enable (nominal 2 MHz enable) |
| cpu_rnw | input | 1 | Processor read (1) / write (0) |
| cpu_addr | input | AW | Processor address |
| vid_addr | input | AW | Video generator RAM address |
| cpu_phi2 | output | 1 | Processor clock phase, high in processor half |
| slot_vid | output | 1 | High during the video half |
| slot_start | output | 1 | First base clock of each RAM slot |
| vid_latch | output | 1 | Video data capture strobe |
| ram_sel_vid | output | 1 | Address multiplexer select, 1 = video address |
| ram_addr | output | AW | Address presented to the RAM |
| ram_we | output | 1 | RAM write strobe (processor only) |
| xcvr_en | output | 1 | Data-bus transceiver enable (joins buses) |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward processor |

## Verification
The bench builds the block with its default values: `DIV`=8, a 16-bit address, a RAM limit of 0x8000 and a 16-byte register window at 0xFE20. With eight base clocks per cycle, every phase count of the video and processor halves is visited many times within a short run. Holding each address pattern for a full cycle exercises the transceiver decode at both edges of the RAM range and of the register window, in both halves. A reset in the middle of the run checks again that counting restarts in the processor half with the buses split.

// File: rtl/dram_slot_pkg.sv
package dram_slot_pkg;

    // Which requester owns the RAM during the current slot.
    typedef enum logic {
        OWNER_VID = 1'b0,
        OWNER_CPU = 1'b1
    } owner_e;

    // Decoded timing state handed from the slot timer to the rest of the block.
    typedef struct packed {
        owner_e owner;      // current slot owner
        logic   slot_start; // first base clock of a slot
        logic   latch;      // last base clock of the video slot
        logic   armed;      // at least one clock since reset
    } phase_t;

    // Decoded bus-side controls.
    typedef struct packed {
        logic xcvr_en;
        logic xcvr_dir;
        logic ram_we;
    } gate_t;

    // True when addr lies below an exclusive upper limit.
    function automatic logic addr_below(input logic [31:0] addr,
                                        input logic [31:0] limit);
        return addr < limit;
    endfunction

    // True when addr lies in an aligned power-of-two block.
    function automatic logic addr_in_block(input logic [31:0] addr,
                                           input logic [31:0] base,
                                           input logic [31:0] span);
        return (addr & ~(span - 32'd1)) == base;
    endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer
    import dram_slot_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic   clk,
    input  logic   rst,
    output phase_t ph
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam logic [CW-1:0] HALF_C = CW'(HALF);
    localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
    localparam logic [CW-1:0] LTCH_C = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= HALF_C;
            armed_q <= 1'b0;
        end else begin
            cnt_q   <= (cnt_q == LAST_C) ? '0 : cnt_q + CW'(1);
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        ph.owner      = (cnt_q >= HALF_C) ? OWNER_CPU : OWNER_VID;
        ph.slot_start = (cnt_q == '0) || (cnt_q == HALF_C);
        ph.latch      = (cnt_q == LTCH_C);
        ph.armed      = armed_q;
    end
endmodule

// File: rtl/bus_gate.sv
module bus_gate
    import dram_slot_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int unsigned RAM_TOP   = 32'h8000,
    parameter int unsigned VREG_BASE = 32'hFE20,
    parameter int unsigned VREG_SPAN = 16,
    parameter bit          VREG_EN   = 1'b1
) (
    input  phase_t          ph,
    input  logic            cpu_en,
    input  logic            cpu_rnw,
    input  logic [AW-1:0]   cpu_addr,
    output gate_t           gate
);
    logic [31:0] addr_w;
    logic        ram_hit;
    logic        vreg_hit;
    logic        cpu_turn;

    assign addr_w  = 32'(cpu_addr);
    assign ram_hit = addr_below(addr_w, RAM_TOP);

    generate
        if (VREG_EN) begin : g_vreg
            assign vreg_hit = addr_in_block(addr_w, VREG_BASE, VREG_SPAN);
        end else begin : g_no_vreg
            assign vreg_hit = 1'b0;
        end
    endgenerate

    assign cpu_turn = (ph.owner == OWNER_CPU) && ph.armed && cpu_en;

    always_comb begin
        gate.xcvr_en  = cpu_turn && (ram_hit || vreg_hit);
        gate.xcvr_dir = gate.xcvr_en && cpu_rnw;
        gate.ram_we   = cpu_turn && !cpu_rnw && ram_hit;
    end
endmodule

// File: rtl/addr_mux.sv
module addr_mux
    import dram_slot_pkg::*;
#(
    parameter int AW = 16
) (
    input  owner_e        owner,
    input  logic [AW-1:0] cpu_addr,
    input  logic [AW-1:0] vid_addr,
    output logic          sel_vid,
    output logic [AW-1:0] ram_addr
);
    assign sel_vid = (owner == OWNER_VID);

    generate
        for (genvar b = 0; b < AW; b++) begin : g_bit
            assign ram_addr[b] = sel_vid ? vid_addr[b] : cpu_addr[b];
        end
    endgenerate
endmodule

// File: rtl/dram_slot_arbiter.sv
module dram_slot_arbiter
    import dram_slot_pkg::*;
#(
    parameter int          DIV       = 8,
    parameter int          AW        = 16,
    parameter int unsigned RAM_TOP   = 32'h8000,
    parameter int unsigned VREG_BASE = 32'hFE20,
    parameter int unsigned VREG_SPAN = 16,
    parameter bit          VREG_EN   = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_en,
    input  logic          cpu_rnw,
    input  logic [AW-1:0] cpu_addr,
    input  logic [AW-1:0] vid_addr,
    output logic          cpu_phi2,
    output logic          slot_vid,
    output logic          slot_start,
    output logic          vid_latch,
    output logic          ram_sel_vid,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic          xcvr_en,
    output logic          xcvr_dir
);
    phase_t ph;
    gate_t  gate;

    slot_timer #(.DIV(DIV)) u_timer (
        .clk (clk),
        .rst (rst),
        .ph  (ph)
    );

    bus_gate #(
        .AW(AW), .RAM_TOP(RAM_TOP), .VREG_BASE(VREG_BASE),
        .VREG_SPAN(VREG_SPAN), .VREG_EN(VREG_EN)
    ) u_gate (
        .ph       (ph),
        .cpu_en   (cpu_en),
        .cpu_rnw  (cpu_rnw),
        .cpu_addr (cpu_addr),
        .gate     (gate)
    );

    addr_mux #(.AW(AW)) u_mux (
        .owner    (ph.owner),
        .cpu_addr (cpu_addr),
        .vid_addr (vid_addr),
        .sel_vid  (ram_sel_vid),
        .ram_addr (ram_addr)
    );

    assign cpu_phi2   = (ph.owner == OWNER_CPU);
    assign slot_vid   = (ph.owner == OWNER_VID);
    assign slot_start = ph.slot_start;
    assign vid_latch  = ph.latch;
    assign ram_we     = gate.ram_we;
    assign xcvr_en    = gate.xcvr_en;
    assign xcvr_dir   = gate.xcvr_dir;
endmodule

// File: rtl/dram_slot_arbiter_chk.sv
module dram_slot_arbiter_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] vid_addr,
    input logic          cpu_phi2,
    input logic          slot_vid,
    input logic          slot_start,
    input logic          vid_latch,
    input logic          ram_sel_vid,
    input logic [AW-1:0] ram_addr,
    input logic          ram_we,
    input logic          xcvr_en,
    input logic          xcvr_dir
);
    a_r1_halves_exclusive: assert property (@(posedge clk) disable iff (rst)
        slot_vid != cpu_phi2);

    a_r2_reset_split: assert property (@(posedge clk)
        (rst && $past(rst)) |-> (cpu_phi2 && !xcvr_en && !ram_we));

    a_r3_video_address: assert property (@(posedge clk) disable iff (rst)
        slot_vid |-> (ram_sel_vid && ram_addr == vid_addr));

    a_r5_split_in_video: assert property (@(posedge clk) disable iff (rst)
        slot_vid |-> !xcvr_en);

    a_r6_dir_needs_enable: assert property (@(posedge clk) disable iff (rst)
        xcvr_dir |-> xcvr_en);

    a_r7_video_read_only: assert property (@(posedge clk) disable iff (rst)
        slot_vid |-> !ram_we);

    a_r8_latch_handoff: assert property (@(posedge clk) disable iff (rst)
        vid_latch |=> (cpu_phi2 && slot_start));

    a_r9_start_single: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> !slot_start);
endmodule

bind dram_slot_arbiter dram_slot_arbiter_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vid_addr    (vid_addr),
    .cpu_phi2    (cpu_phi2),
    .slot_vid    (slot_vid),
    .slot_start  (slot_start),
    .vid_latch   (vid_latch),
    .ram_sel_vid (ram_sel_vid),
    .ram_addr    (ram_addr),
    .ram_we      (ram_we),
    .xcvr_en     (xcvr_en),
    .xcvr_dir    (xcvr_dir)
);

// File: tb/dram_slot_arbiter_tb.sv
module dram_slot_arbiter_tb;
    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;
    localparam int AW   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_en = 1'b0;
    logic          cpu_rnw = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic [AW-1:0] vid_addr = '0;
    logic          cpu_phi2, slot_vid, slot_start, vid_latch, ram_sel_vid;
    logic [AW-1:0] ram_addr;
    logic          ram_we, xcvr_en, xcvr_dir;

    always #10 clk = ~clk;   // 50 MHz

    dram_slot_arbiter #(.DIV(DIV), .AW(AW)) u_dut (
        .clk(clk), .rst(rst), .cpu_en(cpu_en), .cpu_rnw(cpu_rnw),
        .cpu_addr(cpu_addr), .vid_addr(vid_addr), .cpu_phi2(cpu_phi2),
        .slot_vid(slot_vid), .slot_start(slot_start), .vid_latch(vid_latch),
        .ram_sel_vid(ram_sel_vid), .ram_addr(ram_addr), .ram_we(ram_we),
        .xcvr_en(xcvr_en), .xcvr_dir(xcvr_dir)
    );

    typedef struct {
        logic          phi2, svid, sstart, latch, sel, we, xen, xdir;
        logic [AW-1:0] raddr;
        bit            in_rst;
        string         ctx;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // Phase model from R1/R2: reset parks at HALF, then counts modulo DIV.
    int m_cnt   = HALF;
    bit m_armed = 0;
    always @(posedge clk) begin
        if (rst) begin m_cnt <= HALF; m_armed <= 0; end
        else begin m_cnt <= (m_cnt == DIV - 1) ? 0 : m_cnt + 1; m_armed <= 1; end
    end

    task automatic chk(input string req, input string ctx, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s: actual=%0h expected=%0h", req, ctx, what, act, exp);
        end
    endtask

    // Driver: applies one base-clock of stimulus and pushes the expected outputs.
    task automatic step(input logic en, input logic rnw, input logic [AW-1:0] a,
                        input logic [AW-1:0] va, input string ctx);
        exp_t e;
        bit cpu_half, ram_hit, vreg_hit, turn;
        @(negedge clk);
        cpu_en = en; cpu_rnw = rnw; cpu_addr = a; vid_addr = va;
        cpu_half = (m_cnt >= HALF);
        ram_hit  = (a < 16'h8000);
        vreg_hit = ((a & 16'hFFF0) == 16'hFE20);
        turn     = cpu_half && m_armed && en;
        e.phi2   = cpu_half;
        e.svid   = !cpu_half;
        e.sstart = (m_cnt == 0) || (m_cnt == HALF);
        e.latch  = (m_cnt == HALF - 1);
        e.sel    = !cpu_half;
        e.raddr  = cpu_half ? a : va;
        e.xen    = turn && (ram_hit || vreg_hit);
        e.xdir   = e.xen && rnw;
        e.we     = turn && !rnw && ram_hit;
        e.in_rst = rst;
        e.ctx    = ctx;
        q.push_back(e);
    endtask

    // Monitor: pops expected items and compares against the ports mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.in_rst) begin
                    chk("R2", e.ctx, "cpu_phi2", 32'(cpu_phi2), 32'(1'b1));
                    chk("R2", e.ctx, "xcvr_en",  32'(xcvr_en),  32'(1'b0));
                    chk("R2", e.ctx, "ram_we",   32'(ram_we),   32'(1'b0));
                    chk("R2", e.ctx, "xcvr_dir", 32'(xcvr_dir), 32'(1'b0));
                end else begin
                    chk("R1", e.ctx, "cpu_phi2",   32'(cpu_phi2),    32'(e.phi2));
                    chk("R1", e.ctx, "slot_vid",   32'(slot_vid),    32'(e.svid));
                    chk("R9", e.ctx, "slot_start", 32'(slot_start),  32'(e.sstart));
                    chk("R8", e.ctx, "vid_latch",  32'(vid_latch),   32'(e.latch));
                    chk("R3", e.ctx, "ram_sel_vid",32'(ram_sel_vid), 32'(e.sel));
                    chk("R3", e.ctx, "ram_addr",   32'(ram_addr),    32'(e.raddr));
                    chk(e.xen ? "R4" : "R5", e.ctx, "xcvr_en", 32'(xcvr_en), 32'(e.xen));
                    chk("R6", e.ctx, "xcvr_dir",   32'(xcvr_dir),    32'(e.xdir));
                    chk("R7", e.ctx, "ram_we",     32'(ram_we),      32'(e.we));
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // Address patterns: en, rnw, address, label
    logic [AW-1:0] pat_a [8] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFE20,
                                 16'hFE2F, 16'hFE30, 16'hC000, 16'h3000};
    logic          pat_r [8] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    logic          pat_e [8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

    initial begin
        logic [AW-1:0] va;
        va = 16'h1000;
        // R2: reset held with a RAM access pending.
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 16'h0100, va, "r2_reset_hold");
        rst = 1'b0;
        // R1..R9: every pattern held for two full processor cycles.
        for (int p = 0; p < 8; p++) begin
            for (int k = 0; k < 2 * DIV; k++) begin
                va = va + 16'd1;
                step(pat_e[p], pat_r[p], pat_a[p], va, $sformatf("pattern_%0d", p));
            end
        end
        // R2: reset in mid-run, then restart from the processor half.
        rst = 1'b1;
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 16'h0200, va, "r2_midrun_reset");
        rst = 1'b0;
        for (int k = 0; k < 3 * DIV; k++) begin
            va = va + 16'd8;
            step(1'b1, k[0], 16'h4000 + 16'(k), va, "r2_restart");
        end
        step(1'b0, 1'b1, 16'hFFFF, va, "tail");
        wait (q.size() == 0);
        @(negedge clk);
        #5;
        finish_run();
    end
endmodule